// File: doc/BRIEF.md
# ADC Command Queue Sequencer

This block runs two conversion queues over one shared table of 40 command words. Each word holds a six-bit channel number and a pause bit. Queue 1 always starts at entry 0. Queue 2 starts at an entry set by a begin-pointer input. When a queue is triggered, the sequencer reads its words one after another. For each word it issues a one-cycle conversion request to an external converter, then waits for that converter's done pulse before it moves to the next word.

A queue ends when any of these happens:
- it meets the reserved channel code 63;
- it runs past the last table entry;
- for queue 1 only, it reaches the entry where queue 2 begins.

A pause bit makes the queue stop after the current conversion and wait for a new trigger. Several rules of precedence apply. End-of-queue on the same word beats pause. A pause directly followed by an end-of-queue leaves the queue idle, not paused.

Each queue has a sticky pause flag and a sticky completion flag. Software clears them with write-one-to-clear strobes. Each flag drives an interrupt line when its enable is set.

Top module: `adcq_sequencer`

## Requirements
- R1: After reset, both queue statuses read idle (status encoding: 00 idle, 01 active, 10 paused), every flag and interrupt is 0, and no conversion request is raised.
- R2: A command word is 7 bits: bit 6 is the pause bit and bits 5:0 are the channel. Queue 1 starts at entry 0 and queue 2 starts at the begin pointer. Words are converted in ascending entry order. Each conversion raises conv_req for exactly one cycle with conv_chan set to the word's channel. The next word is read only after conv_done.
- R3: A word with channel 63 is end-of-queue. It issues no request, sets that queue's completion flag and returns the queue to idle. If this is the first word after a trigger, no conversion happens at all.
- R4: Any entry index from 40 to 63 is end-of-queue. A queue 2 trigger with its begin pointer at 40 or above completes with no conversion. Queue 2 also ends after entry 39.
- R5: Queue 1 treats the entry named by queue 2's begin pointer as end-of-queue. With that pointer at 0, a queue 1 trigger completes with no conversion.
- R6: A word with its pause bit set is converted first. The queue then sets its pause flag, shows paused, and on its next trigger continues from the following entry.
- R7: If a paused word is followed directly by any end-of-queue condition, that word is still converted. Both the pause and completion flags are set and the status becomes idle. This includes a pause on entry 39.
- R8: A word that has its pause bit set and is also end-of-queue issues no conversion and does not set the pause flag. It sets the completion flag and leaves the queue idle.
- R9: Several end-of-queue conditions on one word behave the same as one.
- R10: Flags stay set until their clear strobe is pulsed. irq_pause and irq_cmpl equal each flag ANDed with its enable bit. Bit 0 of every two-bit flag, strobe, enable and trigger port belongs to queue 1, and bit 1 belongs to queue 2.
- R11: If both queues are pending, queue 1 runs first. A trigger for a queue that is already active is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Command table write enable |
| tbl_waddr | input | 6 | Command table write entry |
| tbl_wdata | input | 7 | Command word {pause, channel} |
| q2_begin | input | 6 | First entry of queue 2 |
| trig | input | 2 | Trigger pulses, bit 0 queue 1 |
| conv_done | input | 1 | Converter finished the requested conversion |
| conv_req | output | 1 | One-cycle conversion request |
| conv_chan | output | 6 | Channel for the request |
| q1_status | output | 2 | Queue 1 status |
| q2_status | output | 2 | Queue 2 status |
| pause_flag | output | 2 | Sticky pause flags |
| cmpl_flag | output | 2 | Sticky completion flags |
| clr_pause | input | 2 | Write-one-to-clear pause flags |
| clr_cmpl | input | 2 | Write-one-to-clear completion flags |
| ie_pause | input | 2 | Pause interrupt enables |
| ie_cmpl | input | 2 | Completion interrupt enables |
| irq_pause | output | 2 | Pause interrupts |
| irq_cmpl | output | 2 | Completion interrupts |

## Verification
Some properties are checked on every cycle:
- a request lasts exactly one cycle;
- a request never carries channel 63;
- a request never comes from an entry past the table end;
- the two queues are never active together;
- flags never drop without their clear strobe.

The remaining behaviour needs the bench's scenarios: the precedence between pause and the three end-of-queue causes, the exact number of conversions and their first channel, resuming after a pause, the priority between queues, and the ignored re-trigger.

// File: rtl/adcq_pkg.sv
package adcq_pkg;

  // Status encoding seen at the ports.
  typedef enum logic [1:0] {
    Q_IDLE   = 2'b00,
    Q_ACTIVE = 2'b01,
    Q_PAUSED = 2'b10
  } qstat_e;

  // Sequencing engine states.
  typedef enum logic [1:0] {
    E_IDLE  = 2'b00,
    E_CHECK = 2'b01,
    E_WAIT  = 2'b10
  } eng_e;

endpackage

// File: rtl/adcq_cmd_table.sv
module adcq_cmd_table #(
  parameter int DEPTH = 40,
  parameter int AW    = 6,
  parameter int CW    = 7,
  parameter int NRD   = 2
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic [CW-1:0]        wdata,
  input  logic [NRD-1:0][AW-1:0] raddr,
  output logic [NRD-1:0][CW-1:0] rdata
);

  localparam logic [AW:0] DEPTH_V = DEPTH[AW:0];

  logic [CW-1:0] mem [DEPTH];

  // Storage has no reset; software programs it before use.
  always_ff @(posedge clk) begin
    if (we && ({1'b0, waddr} < DEPTH_V)) begin
      mem[waddr] <= wdata;
    end
  end

  // Out-of-range reads return zero; the end-of-queue logic flags them anyway.
  for (genvar g = 0; g < NRD; g++) begin : g_rd
    always_comb begin
      if ({1'b0, raddr[g]} < DEPTH_V) begin
        rdata[g] = mem[raddr[g]];
      end else begin
        rdata[g] = '0;
      end
    end
  end

endmodule

// File: rtl/adcq_eoq_detect.sv
module adcq_eoq_detect #(
  parameter int DEPTH    = 40,
  parameter int AW       = 6,
  parameter int CW       = 7,
  parameter int EOQ_CODE = 63
) (
  input  logic [AW-1:0] ptr,
  input  logic [CW-1:0] word,
  input  logic          bound_en,
  input  logic [AW-1:0] bound_ptr,
  output logic          eoq
);

  localparam logic [AW:0]   DEPTH_V = DEPTH[AW:0];
  localparam logic [CW-2:0] CODE_V  = EOQ_CODE[CW-2:0];

  logic past_end;
  logic code_hit;
  logic bound_hit;

  // Any of the three causes ends the queue; overlaps merge into one.
  always_comb begin
    past_end  = ({1'b0, ptr} >= DEPTH_V);
    code_hit  = (word[CW-2:0] == CODE_V);
    bound_hit = bound_en && (ptr == bound_ptr);
    eoq       = past_end | code_hit | bound_hit;
  end

endmodule

// File: rtl/adcq_flags.sv
module adcq_flags #(
  parameter int NQ = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NQ-1:0] set_pause,
  input  logic [NQ-1:0] set_cmpl,
  input  logic [NQ-1:0] clr_pause,
  input  logic [NQ-1:0] clr_cmpl,
  input  logic [NQ-1:0] ie_pause,
  input  logic [NQ-1:0] ie_cmpl,
  output logic [NQ-1:0] pause_flag,
  output logic [NQ-1:0] cmpl_flag,
  output logic [NQ-1:0] irq_pause,
  output logic [NQ-1:0] irq_cmpl
);

  logic [NQ-1:0] pflag_q, pflag_n;
  logic [NQ-1:0] cflag_q, cflag_n;

  for (genvar g = 0; g < NQ; g++) begin : g_q
    // A new event wins over a clear arriving in the same cycle.
    always_comb begin
      pflag_n[g] = pflag_q[g];
      cflag_n[g] = cflag_q[g];
      if (clr_pause[g]) pflag_n[g] = 1'b0;
      if (clr_cmpl[g])  cflag_n[g] = 1'b0;
      if (set_pause[g]) pflag_n[g] = 1'b1;
      if (set_cmpl[g])  cflag_n[g] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pflag_q[g] <= 1'b0;
        cflag_q[g] <= 1'b0;
      end else begin
        pflag_q[g] <= pflag_n[g];
        cflag_q[g] <= cflag_n[g];
      end
    end

    a_r10_pause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (pflag_q[g] && !clr_pause[g]) |=> pflag_q[g]);
    a_r10_cmpl_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (cflag_q[g] && !clr_cmpl[g]) |=> cflag_q[g]);
  end

  assign pause_flag = pflag_q;
  assign cmpl_flag  = cflag_q;
  assign irq_pause  = pflag_q & ie_pause;
  assign irq_cmpl   = cflag_q & ie_cmpl;

endmodule

// File: rtl/adcq_sequencer.sv
module adcq_sequencer #(
  parameter int TBL_DEPTH = 40,
  parameter int PTR_W     = 6,
  parameter int CH_W      = 6,
  parameter int EOQ_CODE  = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tbl_we,
  input  logic [PTR_W-1:0] tbl_waddr,
  input  logic [CH_W:0]    tbl_wdata,
  input  logic [PTR_W-1:0] q2_begin,
  input  logic [1:0]       trig,
  input  logic             conv_done,
  output logic             conv_req,
  output logic [CH_W-1:0]  conv_chan,
  output logic [1:0]       q1_status,
  output logic [1:0]       q2_status,
  output logic [1:0]       pause_flag,
  output logic [1:0]       cmpl_flag,
  input  logic [1:0]       clr_pause,
  input  logic [1:0]       clr_cmpl,
  input  logic [1:0]       ie_pause,
  input  logic [1:0]       ie_cmpl,
  output logic [1:0]       irq_pause,
  output logic [1:0]       irq_cmpl
);
  import adcq_pkg::*;

  localparam int          CW      = CH_W + 1;
  localparam int          NQ      = 2;
  localparam logic [PTR_W:0]  DEPTH_V = TBL_DEPTH[PTR_W:0];
  localparam logic [CH_W-1:0] CODE_V  = EOQ_CODE[CH_W-1:0];

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // State.
  eng_e              eng_q, eng_n;
  logic              cur_q, cur_n;
  logic [PTR_W-1:0]  ptr_q, ptr_n;
  qstat_e            stat_q [NQ];
  qstat_e            stat_n [NQ];
  logic [PTR_W-1:0]  resume_q [NQ];
  logic [PTR_W-1:0]  resume_n [NQ];
  logic [NQ-1:0]     pend_q, pend_n;
  logic              req_q, req_n;
  logic [CH_W-1:0]   chan_q, chan_n;
  logic              pse_q, pse_n;

  logic [NQ-1:0]     set_p, set_c, start;
  logic [PTR_W-1:0]  ptr_inc;
  logic [NQ-1:0][PTR_W-1:0] rd_addr;
  logic [NQ-1:0][CW-1:0]    rd_word;
  logic              eoq_cur, eoq_nxt;
  logic              in_q1;

  assign ptr_inc = ptr_q + 1'b1;
  assign in_q1   = (cur_q == 1'b0);
  assign rd_addr[0] = ptr_q;
  assign rd_addr[1] = ptr_inc;

  adcq_cmd_table #(
    .DEPTH(TBL_DEPTH), .AW(PTR_W), .CW(CW), .NRD(NQ)
  ) u_table (
    .clk   (clk),
    .we    (tbl_we),
    .waddr (tbl_waddr),
    .wdata (tbl_wdata),
    .raddr (rd_addr),
    .rdata (rd_word)
  );

  // Current word and look-ahead word share one detector design.
  adcq_eoq_detect #(
    .DEPTH(TBL_DEPTH), .AW(PTR_W), .CW(CW), .EOQ_CODE(EOQ_CODE)
  ) u_eoq_cur (
    .ptr       (ptr_q),
    .word      (rd_word[0]),
    .bound_en  (in_q1),
    .bound_ptr (q2_begin),
    .eoq       (eoq_cur)
  );

  adcq_eoq_detect #(
    .DEPTH(TBL_DEPTH), .AW(PTR_W), .CW(CW), .EOQ_CODE(EOQ_CODE)
  ) u_eoq_nxt (
    .ptr       (ptr_inc),
    .word      (rd_word[1]),
    .bound_en  (in_q1),
    .bound_ptr (q2_begin),
    .eoq       (eoq_nxt)
  );

  // Next-state logic.
  always_comb begin
    eng_n    = eng_q;
    cur_n    = cur_q;
    ptr_n    = ptr_q;
    stat_n   = stat_q;
    resume_n = resume_q;
    pend_n   = pend_q;
    req_n    = 1'b0;
    chan_n   = chan_q;
    pse_n    = pse_q;
    set_p    = '0;
    set_c    = '0;
    start    = '0;

    unique case (eng_q)
      E_IDLE: begin
        // Fixed priority: queue 1 before queue 2.
        if (pend_q[0]) begin
          start[0]  = 1'b1;
          cur_n     = 1'b0;
          ptr_n     = (stat_q[0] == Q_PAUSED) ? resume_q[0] : '0;
          stat_n[0] = Q_ACTIVE;
          eng_n     = E_CHECK;
        end else if (pend_q[1]) begin
          start[1]  = 1'b1;
          cur_n     = 1'b1;
          ptr_n     = (stat_q[1] == Q_PAUSED) ? resume_q[1] : q2_begin;
          stat_n[1] = Q_ACTIVE;
          eng_n     = E_CHECK;
        end
      end
      E_CHECK: begin
        if (eoq_cur) begin
          // End-of-queue outranks a pause bit in the same word.
          set_c[cur_q]  = 1'b1;
          stat_n[cur_q] = Q_IDLE;
          eng_n         = E_IDLE;
        end else begin
          req_n  = 1'b1;
          chan_n = rd_word[0][CH_W-1:0];
          pse_n  = rd_word[0][CW-1];
          eng_n  = E_WAIT;
        end
      end
      E_WAIT: begin
        if (conv_done) begin
          if (pse_q) begin
            set_p[cur_q] = 1'b1;
            if (eoq_nxt) begin
              set_c[cur_q]  = 1'b1;
              stat_n[cur_q] = Q_IDLE;
            end else begin
              stat_n[cur_q]   = Q_PAUSED;
              resume_n[cur_q] = ptr_inc;
            end
            eng_n = E_IDLE;
          end else begin
            ptr_n = ptr_inc;
            eng_n = E_CHECK;
          end
        end
      end
      default: eng_n = E_IDLE;
    endcase

    // Trigger capture: dropped while the queue is active.
    for (int i = 0; i < NQ; i++) begin
      if (start[i]) begin
        pend_n[i] = 1'b0;
      end else if (trig[i] && (stat_q[i] != Q_ACTIVE)) begin
        pend_n[i] = 1'b1;
      end
    end
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      eng_q  <= E_IDLE;
      cur_q  <= 1'b0;
      ptr_q  <= '0;
      pend_q <= '0;
      req_q  <= 1'b0;
      chan_q <= '0;
      pse_q  <= 1'b0;
      for (int i = 0; i < NQ; i++) begin
        stat_q[i]   <= Q_IDLE;
        resume_q[i] <= '0;
      end
    end else begin
      eng_q  <= eng_n;
      cur_q  <= cur_n;
      ptr_q  <= ptr_n;
      pend_q <= pend_n;
      req_q  <= req_n;
      chan_q <= chan_n;
      pse_q  <= pse_n;
      for (int i = 0; i < NQ; i++) begin
        stat_q[i]   <= stat_n[i];
        resume_q[i] <= resume_n[i];
      end
    end
  end

  adcq_flags #(.NQ(NQ)) u_flags (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .set_pause  (set_p),
    .set_cmpl   (set_c),
    .clr_pause  (clr_pause),
    .clr_cmpl   (clr_cmpl),
    .ie_pause   (ie_pause),
    .ie_cmpl    (ie_cmpl),
    .pause_flag (pause_flag),
    .cmpl_flag  (cmpl_flag),
    .irq_pause  (irq_pause),
    .irq_cmpl   (irq_cmpl)
  );

  assign conv_req  = req_q;
  assign conv_chan = chan_q;
  assign q1_status = stat_q[0];
  assign q2_status = stat_q[1];

  a_r2_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_int_n)
    conv_req |=> !conv_req);
  a_r3_no_eoq_request: assert property (@(posedge clk) disable iff (!rst_int_n)
    conv_req |-> (conv_chan != CODE_V));
  a_r4_req_inside_table: assert property (@(posedge clk) disable iff (!rst_int_n)
    conv_req |-> ({1'b0, ptr_q} < DEPTH_V));
  a_r11_single_active: assert property (@(posedge clk) disable iff (!rst_int_n)
    !((stat_q[0] == Q_ACTIVE) && (stat_q[1] == Q_ACTIVE)));
  a_r2_no_req_while_waiting: assert property (@(posedge clk) disable iff (!rst_int_n)
    (eng_q == E_WAIT) |-> !req_n);

endmodule

// File: tb/adcq_sequencer_tb.sv
module adcq_sequencer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 13;
  localparam logic [1:0] S_IDLE = 2'b00, S_ACT = 2'b01, S_PAU = 2'b10;

  typedef struct packed {
    logic       q;        // 0 = queue 1, 1 = queue 2
    logic [5:0] beg;
    logic [5:0] p1a; logic [5:0] p1c; logic p1p;   // patch 1, addr 63 = none
    logic [5:0] p2a; logic [5:0] p2c; logic p2p;   // patch 2
    logic [5:0] n;        // expected conversions
    logic [5:0] first;    // expected first channel
    logic       ep;
    logic       ec;
    logic [1:0] es;
  } vec_t;

  // Default table: entry i holds channel i, no pause.
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 6'd20, 6'd63, 6'd0,  1'b0, 6'd63, 6'd0,  1'b0, 6'd20, 6'd0,  1'b0, 1'b1, S_IDLE}, // R2 R5
    '{1'b1, 6'd20, 6'd63, 6'd0,  1'b0, 6'd63, 6'd0,  1'b0, 6'd20, 6'd20, 1'b0, 1'b1, S_IDLE}, // R2 R4
    '{1'b0, 6'd0,  6'd63, 6'd0,  1'b0, 6'd63, 6'd0,  1'b0, 6'd0,  6'd0,  1'b0, 1'b1, S_IDLE}, // R5
    '{1'b1, 6'd45, 6'd63, 6'd0,  1'b0, 6'd63, 6'd0,  1'b0, 6'd0,  6'd0,  1'b0, 1'b1, S_IDLE}, // R4
    '{1'b0, 6'd20, 6'd0,  6'd63, 1'b0, 6'd63, 6'd0,  1'b0, 6'd0,  6'd0,  1'b0, 1'b1, S_IDLE}, // R3
    '{1'b0, 6'd20, 6'd5,  6'd5,  1'b1, 6'd63, 6'd0,  1'b0, 6'd6,  6'd0,  1'b1, 1'b0, S_PAU},  // R6
    '{1'b0, 6'd20, 6'd19, 6'd19, 1'b1, 6'd63, 6'd0,  1'b0, 6'd20, 6'd0,  1'b1, 1'b1, S_IDLE}, // R7
    '{1'b1, 6'd30, 6'd39, 6'd39, 1'b1, 6'd63, 6'd0,  1'b0, 6'd10, 6'd30, 1'b1, 1'b1, S_IDLE}, // R7
    '{1'b0, 6'd20, 6'd7,  6'd63, 1'b1, 6'd63, 6'd0,  1'b0, 6'd7,  6'd0,  1'b0, 1'b1, S_IDLE}, // R8
    '{1'b0, 6'd0,  6'd0,  6'd63, 1'b0, 6'd63, 6'd0,  1'b0, 6'd0,  6'd0,  1'b0, 1'b1, S_IDLE}, // R9
    '{1'b1, 6'd10, 6'd12, 6'd12, 1'b1, 6'd63, 6'd0,  1'b0, 6'd3,  6'd10, 1'b1, 1'b0, S_PAU},  // R6
    '{1'b0, 6'd20, 6'd5,  6'd5,  1'b1, 6'd6,  6'd63, 1'b0, 6'd6,  6'd0,  1'b1, 1'b1, S_IDLE}, // R7
    '{1'b1, 6'd40, 6'd63, 6'd0,  1'b0, 6'd63, 6'd0,  1'b0, 6'd0,  6'd0,  1'b0, 1'b1, S_IDLE}  // R4
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tbl_we;
  logic [5:0] tbl_waddr;
  logic [6:0] tbl_wdata;
  logic [5:0] q2_begin;
  logic [1:0] trig;
  logic       conv_done;
  logic       conv_req;
  logic [5:0] conv_chan;
  logic [1:0] q1_status, q2_status, pause_flag, cmpl_flag;
  logic [1:0] clr_pause, clr_cmpl, ie_pause, ie_cmpl, irq_pause, irq_cmpl;

  int total = 0;
  int bad = 0;
  int conv_total;
  logic [5:0] conv_log [64];
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adcq_sequencer u_dut (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_waddr(tbl_waddr),
    .tbl_wdata(tbl_wdata), .q2_begin(q2_begin), .trig(trig),
    .conv_done(conv_done), .conv_req(conv_req), .conv_chan(conv_chan),
    .q1_status(q1_status), .q2_status(q2_status), .pause_flag(pause_flag),
    .cmpl_flag(cmpl_flag), .clr_pause(clr_pause), .clr_cmpl(clr_cmpl),
    .ie_pause(ie_pause), .ie_cmpl(ie_cmpl), .irq_pause(irq_pause),
    .irq_cmpl(irq_cmpl)
  );

  // Converter model: answers each request with done two cycles later.
  initial begin
    conv_done  = 1'b0;
    conv_total = 0;
    forever begin
      @(negedge clk);
      if (conv_req) begin
        conv_log[conv_total % 64] = conv_chan;
        conv_total++;
        @(negedge clk);
        @(negedge clk);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [1:0] stat_of(input logic q);
    return q ? q2_status : q1_status;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; tbl_we = 1'b0; tbl_waddr = '0; tbl_wdata = '0;
    q2_begin = 6'd20; trig = '0; clr_pause = '0; clr_cmpl = '0;
    ie_pause = '0; ie_cmpl = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic write_word(input logic [5:0] a, input logic [6:0] d);
    tbl_we = 1'b1; tbl_waddr = a; tbl_wdata = d;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic load_default();
    for (int i = 0; i < 40; i++) write_word(6'(i), {1'b0, 6'(i)});
  endtask

  task automatic pulse_trig(input logic [1:0] t);
    trig = t;
    @(negedge clk);
    trig = '0;
  endtask

  task automatic wait_idle(input logic q);
    int n = 0;
    repeat (3) @(negedge clk);
    while (stat_of(q) == S_ACT && n < 5000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 5000) check("R2 queue stuck active", 1, 0);
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int base;
    string tag;
    do_reset();
    load_default();
    if (v.p1a != 6'd63) write_word(v.p1a, {v.p1p, v.p1c});
    if (v.p2a != 6'd63) write_word(v.p2a, {v.p2p, v.p2c});
    q2_begin = v.beg;
    base = conv_total;
    pulse_trig(v.q ? 2'b10 : 2'b01);
    wait_idle(v.q);
    repeat (4) @(negedge clk);
    tag = $sformatf("vec%0d R2-R9 table", idx);
    check({tag, " conversions"}, conv_total - base, int'(v.n));
    if (v.n != 0) check({tag, " first channel"}, int'(conv_log[base % 64]), int'(v.first));
    check({tag, " pause flag"}, int'(pause_flag[v.q]), int'(v.ep));
    check({tag, " completion flag"}, int'(cmpl_flag[v.q]), int'(v.ec));
    check({tag, " status"}, int'(stat_of(v.q)), int'(v.es));
  endtask

  // Watchdog: an expired run counts as one failed check.
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int base;
    do_reset();
    // R1: reset state
    check("R1 q1 status", int'(q1_status), 0);
    check("R1 q2 status", int'(q2_status), 0);
    check("R1 flags", int'({pause_flag, cmpl_flag}), 0);
    check("R1 irqs", int'({irq_pause, irq_cmpl}), 0);
    check("R1 conv_req", int'(conv_req), 0);

    for (int i = 0; i < NVEC; i++) run_vec(VEC[i], i);

    // R6: resume after pause continues from the next entry.
    run_vec(VEC[5], 5);
    base = conv_total;
    pulse_trig(2'b01);
    wait_idle(1'b0);
    repeat (4) @(negedge clk);
    check("R6 resume conversions", conv_total - base, 14);
    check("R6 resume first channel", int'(conv_log[base % 64]), 6);
    check("R6 resume completion", int'(cmpl_flag[0]), 1);
    check("R10 pause flag still set", int'(pause_flag[0]), 1);

    // R10: write-one-to-clear and interrupt gating.
    ie_cmpl = 2'b01; ie_pause = 2'b00;
    @(negedge clk);
    check("R10 irq_cmpl enabled", int'(irq_cmpl), 1);
    check("R10 irq_pause masked", int'(irq_pause), 0);
    clr_pause = 2'b01;
    @(negedge clk);
    clr_pause = 2'b00;
    @(negedge clk);
    check("R10 pause cleared", int'(pause_flag[0]), 0);
    check("R10 completion kept", int'(cmpl_flag[0]), 1);
    clr_cmpl = 2'b01;
    @(negedge clk);
    clr_cmpl = 2'b00;
    @(negedge clk);
    check("R10 completion cleared", int'(cmpl_flag[0]), 0);
    check("R10 irq dropped", int'(irq_cmpl), 0);

    // R11: both triggers at once, queue 1 goes first.
    do_reset();
    load_default();
    base = conv_total;
    pulse_trig(2'b11);
    wait_idle(1'b0);
    wait_idle(1'b1);
    repeat (4) @(negedge clk);
    check("R11 priority first channel", int'(conv_log[base % 64]), 0);
    check("R11 both queues converted", conv_total - base, 40);
    check("R11 both completed", int'(cmpl_flag), 3);

    // R11: a trigger while active is dropped.
    do_reset();
    load_default();
    base = conv_total;
    pulse_trig(2'b01);
    repeat (10) @(negedge clk);
    check("R11 queue active", int'(q1_status), 1);
    pulse_trig(2'b01);
    wait_idle(1'b0);
    repeat (30) @(negedge clk);
    check("R11 retrigger ignored", conv_total - base, 20);
    check("R11 status idle", int'(q1_status), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule